// File: doc/BRIEF.md
# Swappable Entropy-Coder Shell with Per-Standard Context

This block surrounds an exchangeable entropy-coding core. Zigzag-ordered coefficients come in over a valid/ready stream and are parked in a local buffer. The buffer takes one of two shapes, chosen by the active coding standard: a single 64-entry block, or four 16-entry slots that are used in rotation. Once a block is complete, the shell replays it to the core over a second valid/ready handshake and marks the last coefficient. The core sends back variable-length codes. The shell packs these codes MSB-first into bytes.

Each standard has its own context slot. A slot holds the count of blocks finished for that standard, the pending code bits that have not yet made a whole byte, and the number of those bits. A swap request is held until the current block is finished. The shell then saves the live context and raises a grant that lets the core be replaced. During the grant, both the input and the core side stay idle. When the done pulse arrives, the shell switches standard, loads the other context and resumes. Two streams can therefore take turns on one core, and each keeps its block numbering and its exact bit alignment.

Top module: `entc_wrap`

## Requirements
- R1: After reset, cfg_mode is 0, blk_idx is 0, reconf_grant, out_valid and core_valid are 0, and in_ready is 1.
- R2: With cfg_mode 0 (large block), exactly 64 coefficients are accepted per block. After the 64th, in_ready stays low until that block's final code has returned.
- R3: With cfg_mode 1 (small blocks), a block is 16 coefficients, and in_ready drops after the 16th. The four 16-entry buffer slots are used in turn, selected by the low two bits of the block count.
- R4: Buffered coefficients go to the core in their arrival order. core_last is 1 exactly on the final coefficient of each block.
- R5: Each code contributes its code_len low bits of code_bits (1 to 8 bits), appended MSB-first to the bit stream of the active mode. Every 8 bits collected produce one out_byte, with its earliest bit at bit 7, in the cycle after the code that completed it.
- R6: blk_idx shows the number of blocks finished in the active mode. It goes up by one when a code with code_last arrives.
- R7: A swap_req that comes in while a block is being filled or coded takes effect only after that block's code_last. A request at an idle block boundary is taken at once. reconf_grant rises with blk_idx already counting the finished block.
- R8: While reconf_grant is 1, in_ready and core_valid are 0 and no coefficient is accepted. The grant stays up until cfg_done.
- R9: A cfg_done pulse during the grant switches cfg_mode to the other mode and clears the grant. From the next cycle, blk_idx shows the restored count of that mode.
- R10: Pending bits (up to 7) and their count are kept per mode across swaps. The bytes of each mode match a packing of that mode's codes alone, with no swaps.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Input coefficient valid |
| in_ready | output | 1 | Shell can take a coefficient |
| in_coef | input | COEF_W | Coefficient, zigzag order |
| core_valid | output | 1 | Coefficient to core valid |
| core_ready | input | 1 | Core takes coefficient |
| core_coef | output | COEF_W | Coefficient to core |
| core_last | output | 1 | Final coefficient of the block |
| code_valid | input | 1 | Code from core valid |
| code_bits | input | CODE_W | Code bits, right-aligned |
| code_len | input | LEN_W | Code length in bits (1..CODE_W) |
| code_last | input | 1 | Code closes the current block |
| out_valid | output | 1 | Packed byte valid |
| out_byte | output | 8 | Packed byte, earliest bit at bit 7 |
| swap_req | input | 1 | Request to exchange the core |
| reconf_grant | output | 1 | Core may be replaced now |
| cfg_done | input | 1 | New core is in place |
| cfg_mode | output | 1 | Active mode: 0 large block, 1 small blocks |
| blk_idx | output | IDX_W | Blocks finished in the active mode |

## Verification
A wrong fill counter or slot base shows up within a few cycles. Either in_ready falls at the wrong coefficient count, or the coefficient stream at the core goes out of order or carries core_last on the wrong entry. A context that is lost or mixed up shows up at the first block after a swap back. blk_idx then shows the wrong count when input resumes, and the first byte that completes afterwards carries misaligned bits. A swap that ignores the block boundary raises reconf_grant while blk_idx has not yet moved, which is visible in the cycle the grant appears.

// File: rtl/entc_pkg.sv
package entc_pkg;
  typedef enum logic {MODE_BIG = 1'b0, MODE_SMALL = 1'b1} mode_e;
  typedef enum logic [1:0] {ST_FILL, ST_DRAIN, ST_SAVE, ST_RECONF} state_e;
  localparam int PEND_W = 7;
  localparam int PCNT_W = 3;
endpackage

// File: rtl/entc_coef_buf.sv
module entc_coef_buf #(
  parameter int COEF_W = 8,
  parameter int DEPTH  = 64,
  localparam int AW    = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              wr_en,
  input  logic [AW-1:0]     wr_addr,
  input  logic [COEF_W-1:0] wr_data,
  input  logic              rd_en,
  input  logic [AW-1:0]     rd_addr,
  output logic [COEF_W-1:0] rd_data
);
  logic [COEF_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_addr] <= wr_data;
    if (rd_en) rd_data <= mem[rd_addr];
  end
endmodule

// File: rtl/entc_bit_packer.sv
module entc_bit_packer
  import entc_pkg::*;
#(
  parameter int CODE_W = 8,
  parameter int LEN_W  = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  input  logic [CODE_W-1:0] in_bits,
  input  logic [LEN_W-1:0]  in_len,
  input  logic              load,
  input  logic [PEND_W-1:0] load_bits,
  input  logic [PCNT_W-1:0] load_cnt,
  output logic [PEND_W-1:0] pend_bits,
  output logic [PCNT_W-1:0] pend_cnt,
  output logic              byte_valid,
  output logic [7:0]        byte_data
);
  localparam int ACC_W = PEND_W + CODE_W;
  localparam int TOT_W = $clog2(ACC_W + 1);

  logic [CODE_W-1:0] len_mask;
  logic [ACC_W-1:0]  acc, acc_sh, rem_mask;
  logic [TOT_W-1:0]  total, sh;
  logic              full;

  always_comb begin
    for (int i = 0; i < CODE_W; i++) len_mask[i] = (i < int'(in_len));
    acc   = (ACC_W'(pend_bits) << in_len) | ACC_W'(in_bits & len_mask);
    total = TOT_W'(pend_cnt) + TOT_W'(in_len);
    full  = (total >= TOT_W'(8));
    sh    = full ? total - TOT_W'(8) : '0;
    acc_sh = acc >> sh;
    for (int i = 0; i < ACC_W; i++) rem_mask[i] = (i < int'(sh));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pend_bits  <= '0;
      pend_cnt   <= '0;
      byte_valid <= 1'b0;
      byte_data  <= '0;
    end else begin
      byte_valid <= 1'b0;
      if (load) begin
        pend_bits <= load_bits;
        pend_cnt  <= load_cnt;
      end else if (in_valid) begin
        if (full) begin
          byte_valid <= 1'b1;
          byte_data  <= acc_sh[7:0];
          pend_bits  <= acc[PEND_W-1:0] & rem_mask[PEND_W-1:0];
          pend_cnt   <= sh[PCNT_W-1:0];
        end else begin
          pend_bits <= acc[PEND_W-1:0];
          pend_cnt  <= total[PCNT_W-1:0];
        end
      end
    end
  end
endmodule

// File: rtl/entc_ctx_store.sv
module entc_ctx_store #(
  parameter int CTX_W = 26
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             save,
  input  logic             wr_sel,
  input  logic [CTX_W-1:0] wr_ctx,
  input  logic             rd_sel,
  output logic [CTX_W-1:0] rd_ctx
);
  logic [CTX_W-1:0] slot [2];

  for (genvar g = 0; g < 2; g++) begin : g_slot
    always_ff @(posedge clk) begin
      if (rst) slot[g] <= '0;
      else if (save && (wr_sel == 1'(g))) slot[g] <= wr_ctx;
    end
  end

  assign rd_ctx = slot[rd_sel];
endmodule

// File: rtl/entc_wrap.sv
module entc_wrap
  import entc_pkg::*;
#(
  parameter int COEF_W  = 8,
  parameter int CODE_W  = 8,
  parameter int LEN_W   = 4,
  parameter int IDX_W   = 16,
  parameter int BIG_N   = 64,
  parameter int SMALL_N = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [COEF_W-1:0] in_coef,
  output logic              core_valid,
  input  logic              core_ready,
  output logic [COEF_W-1:0] core_coef,
  output logic              core_last,
  input  logic              code_valid,
  input  logic [CODE_W-1:0] code_bits,
  input  logic [LEN_W-1:0]  code_len,
  input  logic              code_last,
  output logic              out_valid,
  output logic [7:0]        out_byte,
  input  logic              swap_req,
  output logic              reconf_grant,
  input  logic              cfg_done,
  output logic              cfg_mode,
  output logic [IDX_W-1:0]  blk_idx
);
  localparam int AW       = $clog2(BIG_N);
  localparam int CNT_W    = AW + 1;
  localparam int SMALL_AW = $clog2(SMALL_N);
  localparam int SLOT_W   = AW - SMALL_AW;
  localparam int CTX_W    = IDX_W + PEND_W + PCNT_W;

  mode_e             mode;
  state_e            st;
  logic [CNT_W-1:0]  wr_cnt, rd_cnt, blk_len;
  logic [AW-1:0]     base;
  logic [IDX_W-1:0]  idx;
  logic              swap_pend, q_valid, q_last, adv, rd_en, accept, blk_end;
  logic              restore;
  logic [PEND_W-1:0] pend_bits;
  logic [PCNT_W-1:0] pend_cnt;
  logic [CTX_W-1:0]  ctx_rd;

  assign blk_len = (mode == MODE_BIG) ? CNT_W'(BIG_N) : CNT_W'(SMALL_N);
  assign base    = (mode == MODE_BIG) ? '0
                                      : AW'({idx[SLOT_W-1:0], {SMALL_AW{1'b0}}});
  assign in_ready = (st == ST_FILL) && !(swap_pend && wr_cnt == '0);
  assign accept   = in_valid && in_ready;
  assign adv      = !q_valid || core_ready;
  assign rd_en    = (st == ST_DRAIN) && adv && (rd_cnt < blk_len);
  assign blk_end  = (st == ST_DRAIN) && code_valid && code_last;
  assign restore  = (st == ST_RECONF) && cfg_done;

  entc_coef_buf #(.COEF_W(COEF_W), .DEPTH(BIG_N)) u_buf (
    .clk    (clk),
    .wr_en  (accept),
    .wr_addr(base + wr_cnt[AW-1:0]),
    .wr_data(in_coef),
    .rd_en  (rd_en),
    .rd_addr(base + rd_cnt[AW-1:0]),
    .rd_data(core_coef)
  );

  entc_bit_packer #(.CODE_W(CODE_W), .LEN_W(LEN_W)) u_pack (
    .clk       (clk),
    .rst       (rst),
    .in_valid  (code_valid && st == ST_DRAIN),
    .in_bits   (code_bits),
    .in_len    (code_len),
    .load      (restore),
    .load_bits (ctx_rd[PCNT_W +: PEND_W]),
    .load_cnt  (ctx_rd[PCNT_W-1:0]),
    .pend_bits (pend_bits),
    .pend_cnt  (pend_cnt),
    .byte_valid(out_valid),
    .byte_data (out_byte)
  );

  entc_ctx_store #(.CTX_W(CTX_W)) u_ctx (
    .clk   (clk),
    .rst   (rst),
    .save  (st == ST_SAVE),
    .wr_sel(mode),
    .wr_ctx({idx, pend_bits, pend_cnt}),
    .rd_sel(~mode),
    .rd_ctx(ctx_rd)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      st        <= ST_FILL;
      mode      <= MODE_BIG;
      wr_cnt    <= '0;
      rd_cnt    <= '0;
      idx       <= '0;
      swap_pend <= 1'b0;
      q_valid   <= 1'b0;
      q_last    <= 1'b0;
    end else begin
      if (st == ST_SAVE) swap_pend <= 1'b0;
      else if (swap_req) swap_pend <= 1'b1;

      if (adv) q_valid <= rd_en;
      if (rd_en) begin
        q_last <= (rd_cnt == blk_len - 1'b1);
        rd_cnt <= rd_cnt + 1'b1;
      end

      unique case (st)
        ST_FILL: begin
          if (swap_pend && wr_cnt == '0) st <= ST_SAVE;
          else if (accept) begin
            if (wr_cnt == blk_len - 1'b1) begin
              wr_cnt <= '0;
              rd_cnt <= '0;
              st     <= ST_DRAIN;
            end else begin
              wr_cnt <= wr_cnt + 1'b1;
            end
          end
        end
        ST_DRAIN: begin
          if (blk_end) begin
            idx <= idx + 1'b1;
            st  <= swap_pend ? ST_SAVE : ST_FILL;
          end
        end
        ST_SAVE: st <= ST_RECONF;
        ST_RECONF: begin
          if (cfg_done) begin
            mode <= mode_e'(~mode);
            idx  <= ctx_rd[CTX_W-1 -: IDX_W];
            st   <= ST_FILL;
          end
        end
        default: st <= ST_FILL;
      endcase
    end
  end

  assign core_valid   = q_valid;
  assign core_last    = q_valid && q_last;
  assign reconf_grant = (st == ST_RECONF);
  assign cfg_mode     = mode;
  assign blk_idx      = idx;
endmodule

// File: rtl/entc_wrap_checker.sv
module entc_wrap_checker #(
  parameter int BIG_N   = 64,
  parameter int SMALL_N = 16,
  parameter int IDX_W   = 16
) (
  input logic             clk,
  input logic             rst,
  input logic             in_valid,
  input logic             in_ready,
  input logic             core_valid,
  input logic             code_valid,
  input logic             out_valid,
  input logic             reconf_grant,
  input logic             cfg_mode,
  input logic [IDX_W-1:0] blk_idx
);
  localparam int FC_W = $clog2(BIG_N) + 2;

  logic [FC_W-1:0]  fill_cnt;
  logic [IDX_W-1:0] idx_q;
  logic             mode_q;
  logic             acc;

  assign acc = in_valid && in_ready;

  always_ff @(posedge clk) begin
    if (rst) begin
      fill_cnt <= '0;
      idx_q    <= '0;
      mode_q   <= 1'b0;
    end else begin
      idx_q  <= blk_idx;
      mode_q <= cfg_mode;
      if (blk_idx != idx_q || cfg_mode != mode_q) fill_cnt <= FC_W'(acc);
      else fill_cnt <= fill_cnt + FC_W'(acc);
    end
  end

  // R2 and R3: never more coefficients in a block than its shape holds
  p_fill_bound_r2: assert property (@(posedge clk) disable iff (rst)
    fill_cnt <= (cfg_mode ? FC_W'(SMALL_N) : FC_W'(BIG_N)));

  p_byte_after_code_r5: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> $past(code_valid));

  p_idx_step_r6: assert property (@(posedge clk) disable iff (rst)
    (!$stable(blk_idx) && $stable(cfg_mode)) |-> blk_idx == IDX_W'($past(blk_idx) + 1'b1));

  p_grant_clean_r7: assert property (@(posedge clk) disable iff (rst)
    $rose(reconf_grant) |-> (!$past(core_valid) && !$past(in_ready)));

  p_quiet_reconf_r8: assert property (@(posedge clk) disable iff (rst)
    reconf_grant |-> (!in_ready && !core_valid));

  p_mode_after_grant_r9: assert property (@(posedge clk) disable iff (rst)
    !$stable(cfg_mode) |-> $past(reconf_grant));
endmodule

bind entc_wrap entc_wrap_checker #(.BIG_N(BIG_N), .SMALL_N(SMALL_N), .IDX_W(IDX_W)) u_chk (
  .clk         (clk),
  .rst         (rst),
  .in_valid    (in_valid),
  .in_ready    (in_ready),
  .core_valid  (core_valid),
  .code_valid  (code_valid),
  .out_valid   (out_valid),
  .reconf_grant(reconf_grant),
  .cfg_mode    (cfg_mode),
  .blk_idx     (blk_idx)
);

// File: tb/entc_wrap_bench.sv
module entc_wrap_bench;
  localparam int COEF_W = 8, CODE_W = 8, LEN_W = 4, IDX_W = 16;
  localparam int BIG_N = 64, SMALL_N = 16;

  logic clk = 1'b0, rst = 1'b1;
  logic in_valid = 1'b0, in_ready;
  logic [COEF_W-1:0] in_coef = '0;
  logic core_valid, core_ready, core_last;
  logic [COEF_W-1:0] core_coef;
  logic code_valid, code_last;
  logic [CODE_W-1:0] code_bits;
  logic [LEN_W-1:0] code_len;
  logic out_valid;
  logic [7:0] out_byte;
  logic swap_req = 1'b0, reconf_grant, cfg_done = 1'b0, cfg_mode;
  logic [IDX_W-1:0] blk_idx;

  always #2 clk = ~clk;

  entc_wrap #(.COEF_W(COEF_W), .CODE_W(CODE_W), .LEN_W(LEN_W), .IDX_W(IDX_W),
              .BIG_N(BIG_N), .SMALL_N(SMALL_N)) u_entc_wrap (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready), .in_coef(in_coef),
    .core_valid(core_valid), .core_ready(core_ready), .core_coef(core_coef),
    .core_last(core_last), .code_valid(code_valid), .code_bits(code_bits),
    .code_len(code_len), .code_last(code_last), .out_valid(out_valid),
    .out_byte(out_byte), .swap_req(swap_req), .reconf_grant(reconf_grant),
    .cfg_done(cfg_done), .cfg_mode(cfg_mode), .blk_idx(blk_idx)
  );

  // stand-in core: stalls one cycle in four, one code per coefficient
  logic [1:0] stall_cnt;
  assign core_ready = (stall_cnt != 2'd3);
  always_ff @(posedge clk) begin
    if (rst) begin
      stall_cnt  <= '0;
      code_valid <= 1'b0;
      code_bits  <= '0;
      code_len   <= '0;
      code_last  <= 1'b0;
    end else begin
      stall_cnt  <= stall_cnt + 1'b1;
      code_valid <= core_valid && core_ready;
      code_bits  <= core_coef;
      code_len   <= {1'b0, core_coef[2:0]} + 4'd1;
      code_last  <= core_last;
    end
  end

  int n_chk = 0, n_fail = 0;
  logic [8:0] coef_q[$];
  logic [7:0] byte_q0[$], byte_q1[$];
  int macc[2], mcnt[2], exp_idx[2];

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // scoreboard model: per-mode packing with no swaps
  task automatic model_code(input int m, input logic [7:0] v);
    int len;
    len = int'(v[2:0]) + 1;
    macc[m] = (macc[m] << len) | (int'(v) & ((1 << len) - 1));
    mcnt[m] += len;
    if (mcnt[m] >= 8) begin
      if (m == 0) byte_q0.push_back(8'((macc[m] >> (mcnt[m] - 8)) & 255));
      else        byte_q1.push_back(8'((macc[m] >> (mcnt[m] - 8)) & 255));
      mcnt[m] -= 8;
      macc[m] &= (1 << mcnt[m]) - 1;
    end
  endtask

  task automatic push(input int m, input logic [7:0] v, input bit last, input bit sw);
    @(negedge clk);
    in_valid = 1'b1; in_coef = v; swap_req = sw;
    while (!in_ready) @(negedge clk);
    coef_q.push_back({last, v});
    model_code(m, v);
    @(posedge clk); #1;
    in_valid = 1'b0; swap_req = 1'b0;
  endtask

  task automatic exchange(input int m);
    while (!reconf_grant) @(negedge clk);
    check(blk_idx == IDX_W'(exp_idx[m]), "R7 idx at grant", int'(blk_idx), exp_idx[m]);
    check(cfg_mode == 1'(m), "R7 mode at grant", int'(cfg_mode), m);
    in_valid = 1'b1; in_coef = 8'hAA;
    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      check(!in_ready && !core_valid, "R8 quiet during grant", int'(in_ready), 0);
      check(reconf_grant, "R8 grant held", int'(reconf_grant), 1);
    end
    in_valid = 1'b0;
    cfg_done = 1'b1;
    @(posedge clk); #1;
    cfg_done = 1'b0;
    @(negedge clk);
    check(!reconf_grant, "R9 grant cleared", int'(reconf_grant), 0);
    check(cfg_mode == 1'(1 - m), "R9 mode switched", int'(cfg_mode), 1 - m);
    check(blk_idx == IDX_W'(exp_idx[1 - m]), "R9 restored idx", int'(blk_idx), exp_idx[1 - m]);
  endtask

  task automatic run_block(input int m, input int swap_at);
    int len;
    logic [7:0] v;
    len = (m == 0) ? BIG_N : SMALL_N;
    for (int i = 0; i < len; i++) begin
      v = 8'((m * 37 + exp_idx[m] * 11 + i * 7 + 3) & 255);
      push(m, v, i == len - 1, i == swap_at);
    end
    @(negedge clk);
    check(!in_ready, (m == 0) ? "R2 ready low after 64" : "R3 ready low after 16",
          int'(in_ready), 0);
    exp_idx[m]++;
    if (swap_at >= 0) begin
      check(!reconf_grant, "R7 no grant mid-block", int'(reconf_grant), 0);
      exchange(m);
    end else begin
      while (!in_ready) @(negedge clk);
      check(blk_idx == IDX_W'(exp_idx[m]), "R6 block count", int'(blk_idx), exp_idx[m]);
    end
  endtask

  // monitor
  always @(negedge clk) begin
    if (!rst) begin
      if (core_valid && core_ready) begin
        if (coef_q.size() == 0) check(1'b0, "R4 unexpected coefficient", int'(core_coef), -1);
        else begin
          logic [8:0] e;
          e = coef_q.pop_front();
          check(core_coef == e[7:0], "R4 coefficient order", int'(core_coef), int'(e[7:0]));
          check(core_last == e[8], "R4 last flag", int'(core_last), int'(e[8]));
        end
      end
      if (out_valid) begin
        logic [7:0] eb;
        if ((cfg_mode ? byte_q1.size() : byte_q0.size()) == 0)
          check(1'b0, "R5 unexpected byte", int'(out_byte), -1);
        else begin
          eb = cfg_mode ? byte_q1.pop_front() : byte_q0.pop_front();
          check(out_byte == eb, "R5/R10 packed byte", int'(out_byte), int'(eb));
        end
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    for (int m = 0; m < 2; m++) begin macc[m] = 0; mcnt[m] = 0; exp_idx[m] = 0; end
    repeat (5) @(posedge clk);
    @(negedge clk); rst = 1'b0;
    @(negedge clk);
    check(in_ready, "R1 reset ready", int'(in_ready), 1);
    check(cfg_mode == 1'b0 && blk_idx == '0, "R1 reset mode/idx", int'(blk_idx), 0);
    check(!reconf_grant && !out_valid && !core_valid, "R1 reset quiet", int'(reconf_grant), 0);

    run_block(0, -1);
    run_block(0, 10);          // to small mode
    run_block(1, -1);
    run_block(1, -1);
    run_block(1, 5);           // back to large mode, R10 context kept
    run_block(0, -1);
    // idle-boundary swap: R7
    @(negedge clk); swap_req = 1'b1;
    @(posedge clk); #1; swap_req = 1'b0;
    exchange(0);
    run_block(1, -1);          // fourth slot
    run_block(1, 15);          // slot wraps; swap on last coefficient
    run_block(0, -1);
    repeat (40) @(negedge clk);
    check(coef_q.size() == 0, "R4 all coefficients seen", coef_q.size(), 0);
    check(byte_q0.size() == 0, "R10 mode0 bytes complete", byte_q0.size(), 0);
    check(byte_q1.size() == 0, "R10 mode1 bytes complete", byte_q1.size(), 0);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule